// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-source interrupt state for a bank of interrupt sources, 96 by default. For each source it holds an enable flag, a pending flag, the last sampled input level, a handling-model bit, a trigger-type bit, an 8-bit priority and an 8-bit target byte. Software reaches all of this through a byte-addressed register window with a 12-bit offset. Enable and pending flags each have one window that sets bits and a separate window that clears them. The active flags belong to a neighbouring acknowledge block; they arrive on an input vector and can only be read here. The window also holds a distribution-enable control bit, a read-only count of 32-source groups, a software trigger that names a source by number, and eight read-only identification bytes.

External line n maps to source 32+n. The block samples every line on each clock. A rising level sets the source's pending flag when the source is edge-triggered or enabled. Enabling a level-triggered source whose line is already high also makes it pending. The enable, pending, level and priority vectors are exported to the priority-selection and acknowledge logic, which sits outside this block. An access that the register window does not decode reads as zero, has no effect on a write, and is flagged on a one-cycle error strobe.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the distribution enable is 0. Sources 0 to 14 are enabled and edge-triggered. Every other enable, pending, level, model and trigger bit is 0, and all priority and target bytes are 0.
- R2: Offset 0x000 bit 0 is the distribution enable and is read/write. Offsets 0x001 to 0x003 read 0 and ignore writes without error. Offset 0x004 reads NUM_SRC/32-1, which is 2 by default. Offsets 0x005 to 0x007 read 0. Writes to 0x004 to 0x007 are errors. Read data and the error strobe appear in the cycle after the request.
- R3: Writing a 1 to bit i at offset 0x100+k enables source 8k+i. Writing a 1 to bit i at 0x180+k disables it. A 0 bit has no effect. A read from either offset returns the enable bits of sources 8k to 8k+7.
- R4: Offset 0x200+k sets pending bits and 0x280+k clears them, with the same bit layout as R3, and reads from either return the pending bits. Offset 0x300+k reads the active input bits of sources 8k to 8k+7. A write there is an error.
- R5: Offset 0x400+n holds the priority byte of source n and 0x800+n holds its target byte. Both are read/write. Priority n appears on prio_o[8n+7:8n].
- R6: Offset 0xC00+k holds two bits each for sources 4k to 4k+3. Source 4k+i uses bit 2i as the handling model and bit 2i+1 as the trigger type, where 1 means edge.
- R7: Line n drives source 32+n. A rising level sets pending when the source is edge-triggered or enabled. A falling level only updates the stored level. A level that does not change has no effect.
- R8: A set-enable write to a level-triggered source whose line is high also sets its pending bit. An edge-triggered source is not made pending this way.
- R9: A halfword write to 0xF00 sets the pending bit of the source numbered by wdata_i[9:0]. A byte write to 0xF00, or a number of NUM_SRC or more, is an error.
- R10: A read at 0xFE0+4k returns byte k of ID_VALUE, for k from 0 to 7. The unaligned offsets in that range read 0.
- R11: An unmapped offset, or a byte or source index beyond the configured sources, reads 0 and leaves all state unchanged on a write. It also raises err_o for one cycle.
- R12: When a line rises in the same cycle as a clear-pending write to that source, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC-32 | External interrupt lines; line n drives source 32+n |
| act_i | input | NUM_SRC | Active flags from the acknowledge logic |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| half_i | input | 1 | Halfword write; only meaningful at 0xF00 |
| addr_i | input | 12 | Byte offset into the register window |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle strobe for a rejected access |
| dist_en_o | output | 1 | Distribution enable |
| en_o | output | NUM_SRC | Enable flags |
| pend_o | output | NUM_SRC | Pending flags |
| lvl_o | output | NUM_SRC | Stored input levels |
| prio_o | output | 8*NUM_SRC | Priority bytes, source n at bits 8n+7:8n |

## Verification
Two paths can write a pending bit in the same clock: a software clear-pending write and a rising external line. The bench drives both on the same falling edge for one edge-triggered source and then reads the pending byte back; the bit must be set. A second coincidence is a set-enable write to a level-triggered source in the cycle its line is already high. That write must make the source pending, while the same write to an edge-triggered source with its line high must not.

// File: rtl/dist_pkg.sv
package dist_pkg;
  typedef enum logic [3:0] {
    K_BAD, K_ZERO, K_CTRL, K_GRP, K_ENS, K_ENC, K_PDS, K_PDC,
    K_ACT, K_PRIO, K_TGT, K_CFG, K_SWT, K_ID
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       err;
    logic [9:0] idx;
  } dec_t;
endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic        we_i,
  input  logic        half_i,
  input  logic [11:0] addr_i,
  input  logic [9:0]  swt_id_i,
  output dec_t        dec_o
);
  localparam int unsigned EN_BYTES  = NUM_SRC / 8;
  localparam int unsigned CFG_BYTES = NUM_SRC / 4;

  always_comb begin
    dec_o = '{kind: K_BAD, err: 1'b1, idx: '0};
    case (addr_i[11:8])
      4'h0: if (addr_i[7:3] == 5'd0) begin
        dec_o.err = 1'b0;
        if (addr_i[2:0] == 3'd0) dec_o.kind = K_CTRL;
        else if (addr_i[2:0] == 3'd4) begin
          dec_o.kind = K_GRP;
          dec_o.err  = we_i;
        end else begin
          dec_o.kind = K_ZERO;
          dec_o.err  = we_i && addr_i[2];
        end
      end
      4'h1, 4'h2: begin
        dec_o.idx  = {3'b0, addr_i[6:0]};
        dec_o.kind = addr_i[9] ? (addr_i[7] ? K_PDC : K_PDS)
                               : (addr_i[7] ? K_ENC : K_ENS);
        dec_o.err  = dec_o.idx >= 10'(EN_BYTES);
      end
      4'h3: if (!addr_i[7]) begin
        dec_o.idx  = {3'b0, addr_i[6:0]};
        dec_o.kind = K_ACT;
        dec_o.err  = we_i || (dec_o.idx >= 10'(EN_BYTES));
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        dec_o.idx  = addr_i[9:0];
        dec_o.kind = K_PRIO;
        dec_o.err  = dec_o.idx >= 10'(NUM_SRC);
      end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        dec_o.idx  = addr_i[9:0];
        dec_o.kind = K_TGT;
        dec_o.err  = dec_o.idx >= 10'(NUM_SRC);
      end
      4'hC, 4'hD, 4'hE: begin
        dec_o.idx  = addr_i[9:0];
        dec_o.kind = K_CFG;
        dec_o.err  = dec_o.idx >= 10'(CFG_BYTES);
      end
      default: begin
        if (addr_i[7:0] == 8'h00) begin
          dec_o.idx  = swt_id_i;
          dec_o.kind = K_SWT;
          dec_o.err  = !we_i || !half_i || (swt_id_i >= 10'(NUM_SRC));
        end else if (addr_i[7:5] == 3'b111) begin
          dec_o.idx  = {7'b0, addr_i[4:2]};
          dec_o.kind = (addr_i[1:0] == 2'b00) ? K_ID : K_ZERO;
          dec_o.err  = we_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/dist_flags.sv
module dist_flags
  import dist_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 96,
  parameter int unsigned NUM_FIXED = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  dec_t               dec_i,
  input  logic [7:0]         wdata_i,
  input  logic [NUM_SRC-33:0] irq_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pd_o,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] mod_o,
  output logic [NUM_SRC-1:0] edg_o
);
  logic unused_err;
  assign unused_err = dec_i.err;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned B8 = s / 8;
    localparam int unsigned B4 = s / 4;
    logic en_r, pd_r, lvl_r, mod_r, edg_r;
    logic hit8, hit4, sw_hit, en_set, en_clr, pd_set, pd_clr;
    logic lvl_d, rise, en_d, pd_d;

    if (s >= 32) begin : g_ext
      assign lvl_d = irq_i[s-32];
    end else begin : g_int
      assign lvl_d = 1'b0;
    end

    assign hit8   = wr_i && (dec_i.idx == 10'(B8)) && wdata_i[s%8];
    assign hit4   = wr_i && (dec_i.kind == K_CFG) && (dec_i.idx == 10'(B4));
    assign sw_hit = wr_i && (dec_i.kind == K_SWT) && (dec_i.idx == 10'(s));
    assign en_set = hit8 && (dec_i.kind == K_ENS);
    assign en_clr = hit8 && (dec_i.kind == K_ENC);
    assign pd_set = hit8 && (dec_i.kind == K_PDS);
    assign pd_clr = hit8 && (dec_i.kind == K_PDC);

    assign en_d = (en_r | en_set) & ~en_clr;
    assign rise = lvl_d & ~lvl_r;
    // hardware set events take precedence over a software clear in the same cycle
    assign pd_d = (pd_r & ~pd_clr) | pd_set | sw_hit
                | (rise & (edg_r | en_d))
                | (en_set & lvl_d & ~edg_r);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r  <= 1'(s < NUM_FIXED);
        edg_r <= 1'(s < NUM_FIXED);
        pd_r  <= 1'b0;
        lvl_r <= 1'b0;
        mod_r <= 1'b0;
      end else begin
        en_r  <= en_d;
        pd_r  <= pd_d;
        lvl_r <= lvl_d;
        if (hit4) begin
          mod_r <= wdata_i[2*(s%4)];
          edg_r <= wdata_i[2*(s%4)+1];
        end
      end
    end

    assign en_o[s]  = en_r;
    assign pd_o[s]  = pd_r;
    assign lvl_o[s] = lvl_r;
    assign mod_o[s] = mod_r;
    assign edg_o[s] = edg_r;

    AST_EDGE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise && edg_r) |=> pd_r); // R7
    AST_FALL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_d && lvl_r && !wr_i) |=> $stable(pd_r)); // R7
    AST_EN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_set && lvl_d && !edg_r) |=> pd_r); // R8
  end
endmodule

// File: rtl/dist_bytes.sv
module dist_bytes
  import dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  dec_t                 dec_i,
  input  logic [7:0]           wdata_i,
  output logic [8*NUM_SRC-1:0] prio_o,
  output logic [7:0]           rd_prio_o,
  output logic [7:0]           rd_tgt_o
);
  logic unused_err;
  assign unused_err = dec_i.err;
  logic [7:0] tgt [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [7:0] pr_r, tg_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pr_r <= '0;
        tg_r <= '0;
      end else if (wr_i && (dec_i.idx == 10'(s))) begin
        if (dec_i.kind == K_PRIO) pr_r <= wdata_i;
        if (dec_i.kind == K_TGT)  tg_r <= wdata_i;
      end
    end
    assign prio_o[8*s +: 8] = pr_r;
    assign tgt[s] = tg_r;
  end

  always_comb begin
    rd_prio_o = '0;
    rd_tgt_o  = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (dec_i.idx == 10'(n)) begin
        rd_prio_o = prio_o[8*n +: 8];
        rd_tgt_o  = tgt[n];
      end
    end
  end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import dist_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 96,
  parameter int unsigned NUM_FIXED = 15,
  parameter logic [63:0] ID_VALUE  = 64'h5A3C_0F21_8E47_D6B2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-33:0]  irq_i,
  input  logic [NUM_SRC-1:0]   act_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 half_i,
  input  logic [11:0]          addr_i,
  input  logic [15:0]          wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 err_o,
  output logic                 dist_en_o,
  output logic [NUM_SRC-1:0]   en_o,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic [NUM_SRC-1:0]   lvl_o,
  output logic [8*NUM_SRC-1:0] prio_o
);
  localparam int unsigned EN_BYTES  = NUM_SRC / 8;
  localparam int unsigned CFG_BYTES = NUM_SRC / 4;
  localparam logic [7:0]  GROUPS    = 8'(NUM_SRC / 32 - 1);

  dec_t dec;
  logic wr;
  logic [NUM_SRC-1:0] mod, edg;
  logic [7:0] rd_prio, rd_tgt, rd_d;
  logic unused_hi;
  assign unused_hi = ^wdata_i[15:10];

  dist_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .we_i(we_i), .half_i(half_i), .addr_i(addr_i),
    .swt_id_i(wdata_i[9:0]), .dec_o(dec)
  );

  assign wr = req_i && we_i && !dec.err;

  dist_flags #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .dec_i(dec),
    .wdata_i(wdata_i[7:0]), .irq_i(irq_i),
    .en_o(en_o), .pd_o(pend_o), .lvl_o(lvl_o), .mod_o(mod), .edg_o(edg)
  );

  dist_bytes #(.NUM_SRC(NUM_SRC)) u_bytes (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .dec_i(dec),
    .wdata_i(wdata_i[7:0]), .prio_o(prio_o),
    .rd_prio_o(rd_prio), .rd_tgt_o(rd_tgt)
  );

  function automatic logic [7:0] byte_of(input logic [NUM_SRC-1:0] v, input logic [9:0] k);
    logic [7:0] r = '0;
    for (int b = 0; b < EN_BYTES; b++)
      if (k == 10'(b)) r = v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [7:0] cfg_of(input logic [9:0] k);
    logic [7:0] r = '0;
    for (int b = 0; b < CFG_BYTES; b++)
      if (k == 10'(b))
        for (int i = 0; i < 4; i++) begin
          r[2*i]   = mod[4*b+i];
          r[2*i+1] = edg[4*b+i];
        end
    return r;
  endfunction

  always_comb begin
    case (dec.kind)
      K_CTRL:         rd_d = {7'b0, dist_en_o};
      K_GRP:          rd_d = GROUPS;
      K_ENS, K_ENC:   rd_d = byte_of(en_o, dec.idx);
      K_PDS, K_PDC:   rd_d = byte_of(pend_o, dec.idx);
      K_ACT:          rd_d = byte_of(act_i, dec.idx);
      K_PRIO:         rd_d = rd_prio;
      K_TGT:          rd_d = rd_tgt;
      K_CFG:          rd_d = cfg_of(dec.idx);
      K_ID:           rd_d = ID_VALUE[8*dec.idx[2:0] +: 8];
      default:        rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_en_o <= 1'b0;
      rdata_o   <= '0;
      err_o     <= 1'b0;
    end else begin
      if (wr && dec.kind == K_CTRL) dist_en_o <= wdata_i[0];
      rdata_o <= (req_i && !we_i && !dec.err) ? rd_d : 8'h00;
      err_o   <= req_i && dec.err;
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && dec.err) |=> ($stable(en_o) && $stable(prio_o) && $stable(dist_en_o))); // R11
  AST_ACT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[11:7] == 5'b00110) |=> err_o); // R4
endmodule

// File: tb/irq_dist_regs_test.sv
module irq_dist_regs_test;
  localparam int N = 96;
  localparam logic [63:0] IDV = 64'h5A3C_0F21_8E47_D6B2;

  logic clk = 0, rst_n = 0;
  logic [N-33:0] irq = '0;
  logic [N-1:0] act = '0;
  logic req = 0, we = 0, half = 0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0] rdata;
  logic err, dist_en;
  logic [N-1:0] en, pend, lvl;
  logic [8*N-1:0] prio;
  int total = 0, fails = 0;
  logic [N-1:0] m_en, m_pd;
  logic [7:0] v;
  logic [8*N-1:0] snap;

  always #5 clk = ~clk;

  irq_dist_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .act_i(act), .req_i(req),
    .we_i(we), .half_i(half), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .dist_en_o(dist_en), .en_o(en),
    .pend_o(pend), .lvl_o(lvl), .prio_o(prio)
  );

  task automatic chk(input string tag, input longint act_v, input longint exp_v);
    total++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic acc(input logic w, input logic h, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = w; half = h; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0; half = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] r);
    acc(0, 0, a, 16'h0);
    r = rdata;
  endtask

  task automatic step_irq(input logic [N-33:0] val);
    @(negedge clk); irq = val;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 dist_en", dist_en, 0);
    for (int k = 0; k < 12; k++) begin
      logic [7:0] e = '0;
      for (int i = 0; i < 8; i++) e[i] = (8*k+i) < 15;
      rd(12'h100 + 12'(k), v); chk("R1 enable", v, e);
      rd(12'h200 + 12'(k), v); chk("R1 pending", v, 0);
    end
    for (int k = 0; k < 24; k++) begin
      logic [7:0] e = '0;
      for (int i = 0; i < 4; i++) e[2*i+1] = (4*k+i) < 15;
      rd(12'hC00 + 12'(k), v); chk("R1 config", v, e);
    end
    chk("R1 prio_o", prio, 0);
    rd(12'h85F, v); chk("R1 target", v, 0);

    // R2 control block
    rd(12'h004, v); chk("R2 groups", v, 2);
    acc(1, 0, 12'h000, 16'h00FF); chk("R2 ctrl err", err, 0);
    rd(12'h000, v); chk("R2 ctrl read", v, 1);
    chk("R2 dist_en_o", dist_en, 1);
    acc(1, 0, 12'h002, 16'h00FF); chk("R2 reserved write err", err, 0);
    rd(12'h002, v); chk("R2 reserved read", v, 0);
    acc(1, 0, 12'h004, 16'h0007); chk("R2 groups write err", err, 1);
    rd(12'h004, v); chk("R2 groups kept", v, 2);

    // R3 enable set/clear sweep
    m_en = '0;
    for (int i = 0; i < 15; i++) m_en[i] = 1'b1;
    for (int k = 0; k < 12; k++) begin
      logic [7:0] p = 8'((k*37 + 5) & 255);
      acc(1, 0, 12'h100 + 12'(k), {8'h0, p});
      m_en[8*k +: 8] = m_en[8*k +: 8] | p;
    end
    for (int k = 0; k < 12; k++) begin
      logic [7:0] q = 8'((k*91 + 66) & 255);
      acc(1, 0, 12'h180 + 12'(k), {8'h0, q});
      m_en[8*k +: 8] = m_en[8*k +: 8] & ~q;
    end
    for (int k = 0; k < 12; k++) begin
      rd(12'h100 + 12'(k), v); chk("R3 set window", v, m_en[8*k +: 8]);
      rd(12'h180 + 12'(k), v); chk("R3 clear window", v, m_en[8*k +: 8]);
    end
    chk("R3 en_o", en, m_en);

    // R4 pending set/clear sweep
    m_pd = '0;
    for (int k = 0; k < 12; k++) begin
      logic [7:0] p = 8'((k*29 + 113) & 255);
      acc(1, 0, 12'h200 + 12'(k), {8'h0, p});
      m_pd[8*k +: 8] = p;
    end
    for (int k = 0; k < 12; k++) begin
      logic [7:0] q = 8'((k*73 + 9) & 255);
      acc(1, 0, 12'h280 + 12'(k), {8'h0, q});
      m_pd[8*k +: 8] = m_pd[8*k +: 8] & ~q;
    end
    for (int k = 0; k < 12; k++) begin
      rd(12'h280 + 12'(k), v); chk("R4 pending", v, m_pd[8*k +: 8]);
    end
    chk("R4 pend_o", pend, m_pd);
    act = {32'hA5C3_0F96, 32'h1234_5678, 32'hDEAD_0BEE};
    for (int k = 0; k < 12; k++) begin
      rd(12'h300 + 12'(k), v); chk("R4 active", v, act[8*k +: 8]);
    end
    acc(1, 0, 12'h300, 16'h00FF); chk("R4 active write err", err, 1);
    chk("R4 active write no effect", pend, m_pd);

    // R5 priority and target sweep
    for (int n = 0; n < N; n++) begin
      acc(1, 0, 12'h400 + 12'(n), 16'((n*7 + 3) & 255));
      acc(1, 0, 12'h800 + 12'(n), 16'(n ^ 8'h5A));
    end
    for (int n = 0; n < N; n++) begin
      rd(12'h400 + 12'(n), v); chk("R5 priority", v, (n*7 + 3) & 255);
      rd(12'h800 + 12'(n), v); chk("R5 target", v, n ^ 8'h5A);
      chk("R5 prio_o", prio[8*n +: 8], (n*7 + 3) & 255);
    end

    // R6 configuration sweep
    for (int k = 0; k < 24; k++) acc(1, 0, 12'hC00 + 12'(k), 16'((k*53 + 17) & 255));
    for (int k = 0; k < 24; k++) begin
      rd(12'hC00 + 12'(k), v); chk("R6 config", v, (k*53 + 17) & 255);
    end

    // clean slate for input tests
    for (int k = 0; k < 12; k++) begin
      acc(1, 0, 12'h180 + 12'(k), 16'h00FF);
      acc(1, 0, 12'h280 + 12'(k), 16'h00FF);
    end
    acc(1, 0, 12'hC08, 16'h0002);  // src32 edge, 33..35 level
    acc(1, 0, 12'hC09, 16'h0000);
    acc(1, 0, 12'hC0A, 16'h0002);  // src40 edge
    acc(1, 0, 12'h104, 16'h0004);  // enable src34

    // R7 input rules
    step_irq(64'h7);
    chk("R7 lvl_o", lvl[35:32], 4'h7);
    rd(12'h204, v); chk("R7 rise pending", v, 8'h05);
    step_irq(64'h0);
    chk("R7 fall lvl_o", lvl[35:32], 4'h0);
    rd(12'h204, v); chk("R7 fall keeps pending", v, 8'h05);
    acc(1, 0, 12'h284, 16'h00FF);
    step_irq(64'h1);
    acc(1, 0, 12'h284, 16'h0001);
    repeat (3) @(posedge clk);
    rd(12'h204, v); chk("R7 steady level ignored", v, 8'h00);

    // R8 enable with line high
    step_irq(64'h9);
    rd(12'h204, v); chk("R8 disabled level no pend", v, 8'h00);
    acc(1, 0, 12'h104, 16'h0009);
    rd(12'h204, v); chk("R8 enable level pends", v, 8'h08);
    step_irq(64'h0);
    acc(1, 0, 12'h284, 16'h00FF);

    // R12 rise coincides with clear-pending write
    @(negedge clk);
    irq = 64'h100; req = 1; we = 1; addr = 12'h285; wdata = 16'h0001;
    @(posedge clk); #1; req = 0; we = 0;
    rd(12'h205, v); chk("R12 rise beats clear", v, 8'h01);
    step_irq(64'h0);

    // R9 software trigger
    acc(1, 1, 12'hF00, 16'h0C05); chk("R9 trigger err", err, 0);
    rd(12'h200, v); chk("R9 trigger src5", v, 8'h20);
    acc(1, 1, 12'hF00, 16'h0041);
    rd(12'h208, v); chk("R9 trigger src65", v, 8'h02);
    acc(1, 0, 12'hF00, 16'h0003); chk("R9 byte write err", err, 1);
    acc(1, 1, 12'hF00, 16'h0060); chk("R9 range err", err, 1);
    rd(12'h200, v); chk("R9 no extra pending", v, 8'h20);

    // R10 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4*k), v); chk("R10 id byte", v, IDV[8*k +: 8]);
      rd(12'hFE1 + 12'(4*k + (k % 3)), v); chk("R10 unaligned", v, 0);
    end

    // R11 errors
    rd(12'h008, v); chk("R11 err 0x008", err, 1); chk("R11 data 0x008", v, 0);
    rd(12'h160, v); chk("R11 err enable idx", err, 1);
    rd(12'h4A0, v); chk("R11 err prio idx", err, 1); chk("R11 data prio", v, 0);
    rd(12'hC20, v); chk("R11 err cfg idx", err, 1);
    rd(12'hF80, v); chk("R11 err 0xF80", err, 1);
    rd(12'h000, v); chk("R11 strobe one cycle", err, 0);
    snap = prio;
    acc(1, 0, 12'h460, 16'h0077); chk("R11 write err", err, 1);
    chk("R11 write ignored", prio, snap);

    finish_run();
  end
endmodule